// File: doc/BRIEF.md
# Fixed-Point Network Time Accumulator

This block keeps a free-running 64-bit time-of-day count for a network controller. The count is a fixed-point number. Its upper bits are whole nanoseconds and its lower `FRAC_W` bits are fractions of a nanosecond. On every reference clock edge the block adds a programmable increment to the count. The nanosecond value is therefore the raw count shifted right by `FRAC_W`.

Software trims the clock rate by rewriting the increment. The new value is the base increment plus or minus base·ppb/10^9. The default parameters suit a 125 MHz reference: an increment of 0x2000000 with 22 fractional bits gives 8 ns per cycle.

A small register port serves all software access:
- write the increment;
- set the time with an atomic two-word write;
- read the time as two 32-bit halves that belong to one snapshot.

Capture units elsewhere in the controller take the live raw time and the live nanosecond value from dedicated outputs.

Top module: `systime_accum`

## Requirements
- R1: After reset, `timeNow`, the increment, `regRdValid` and `incOverflow` are all zero. With no register writes, `timeNow` stays at zero, so the counter is stopped.
- R2: On every clock edge without a time commit, `timeNow` becomes `timeNow` plus the zero-extended increment, modulo 2^64. For example, 0xFFFFFFFF_FFFFFFF0 plus 0x2000000 gives 0x00000000_01FFFFF0.
- R3: A write to register 0 whose upper bits (`regWrData[31:INC_W]`) are all zero loads the increment. The edge that takes the write still adds the old increment. The new increment applies from the following edge, and the accumulated count is not disturbed.
- R4: A write to register 0 with any bit at or above `INC_W` set is refused. The increment keeps its old value and `incOverflow` is high for exactly the one cycle after the write edge.
- R5: A write to register 1 stores the data as the pending low word of a time load. It does not change `timeNow`, which keeps advancing.
- R6: A write to register 2 replaces `timeNow` in one edge with {write data, pending low word}. The increment is added again from the next edge on.
- R7: A read of register 1 returns bits 31:0 of `timeNow` as it was at the read edge. The same edge latches bits 63:32 into a shadow. A later read of register 2 returns that shadow, however much time has passed.
- R8: Read data and `regRdValid` appear in the cycle after `regRdEn`. `regRdValid` is low in cycles without a read. Register 0 reads return the increment zero-extended, and register 3 reads return zero.
- R9: `nsNow` always equals `timeNow` shifted right by `FRAC_W` bits (22 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that advances the count |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 increment, 1 time low, 2 time high, 3 unused |
| regWrData | input | BUS_W (32) | Write data |
| regRdData | output | BUS_W (32) | Read data, valid with regRdValid |
| regRdValid | output | 1 | One-cycle read completion pulse |
| incOverflow | output | 1 | One-cycle pulse when an increment write is refused |
| timeNow | output | 2*BUS_W (64) | Live raw fixed-point time |
| nsNow | output | 2*BUS_W (64) | Live time in whole nanoseconds |

## Verification
The checker assumes that reset is held from time zero and that the register strobes are clean single-cycle levels sampled at the rising edge. It also assumes that a read and a write issued in the same cycle act independently.

The bench drives every input on the falling edge and reads every output one falling edge later, so each edge sees settled stimulus. Increment values are chosen on both sides of the field limit, and time loads are chosen so that carries cross the 32-bit and 64-bit boundaries. This lets the wrap, refusal and snapshot rules be observed directly at the ports.

// File: rtl/systime_pkg.sv
package systime_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_INC  = 2'd0,
    REG_TLO  = 2'd1,
    REG_THI  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic     incLoad;
    logic     incReject;
    logic     stageLoad;
    logic     timeCommit;
    logic     rdValidNext;
    reg_sel_e rdSel;
  } ctl_strobe_t;

endpackage

// File: rtl/systime_ctrl.sv
module systime_ctrl
  import systime_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int INC_W = 26
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output ctl_strobe_t           strobes,
  output logic                  incOverflow
);

  reg_sel_e addrSel;
  logic     incFits;

  assign addrSel = reg_sel_e'(regAddr);

  // The increment field may span the whole bus, in which case every value fits
  generate
    if (INC_W >= BUS_W) begin : gFullField
      assign incFits = 1'b1;
    end else begin : gNarrowField
      assign incFits = ((regWrData >> INC_W) == '0);
    end
  endgenerate

  always_comb begin
    strobes             = '0;
    strobes.incLoad     = regWrEn && (addrSel == REG_INC) && incFits;
    strobes.incReject   = regWrEn && (addrSel == REG_INC) && !incFits;
    strobes.stageLoad   = regWrEn && (addrSel == REG_TLO);
    strobes.timeCommit  = regWrEn && (addrSel == REG_THI);
    strobes.rdValidNext = regRdEn;
    strobes.rdSel       = addrSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incOverflow <= 1'b0;
    end else begin
      incOverflow <= strobes.incReject;
    end
  end

endmodule

// File: rtl/systime_dp.sv
module systime_dp
  import systime_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int INC_W = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strobes,
  input  logic [BUS_W-1:0]     wrData,
  output logic [2*BUS_W-1:0]   timeNow,
  output logic [INC_W-1:0]     incValue,
  output logic [BUS_W-1:0]     stageLow,
  output logic [BUS_W-1:0]     rdData,
  output logic                 rdValid
);

  localparam int TIME_W = 2 * BUS_W;

  logic [TIME_W-1:0] timeReg;
  logic [TIME_W-1:0] incExt;
  logic [INC_W-1:0]  incReg;
  logic [BUS_W-1:0]  stageReg;
  logic [BUS_W-1:0]  shadowHi;

  assign incExt = TIME_W'(incReg);

  // Accumulator: atomic load wins over the advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeReg <= '0;
    end else if (strobes.timeCommit) begin
      timeReg <= {wrData, stageReg};
    end else begin
      timeReg <= timeReg + incExt;
    end
  end

  // Increment and staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incReg   <= '0;
      stageReg <= '0;
    end else begin
      if (strobes.incLoad) begin
        incReg <= INC_W'(wrData);
      end
      if (strobes.stageLoad) begin
        stageReg <= wrData;
      end
    end
  end

  // Read path with high-word shadow for coherent two-word reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      shadowHi <= '0;
    end else begin
      rdValid <= strobes.rdValidNext;
      rdData  <= '0;
      if (strobes.rdValidNext) begin
        unique case (strobes.rdSel)
          REG_INC: rdData <= BUS_W'(incReg);
          REG_TLO: begin
            rdData   <= timeReg[BUS_W-1:0];
            shadowHi <= timeReg[TIME_W-1:BUS_W];
          end
          REG_THI:  rdData <= shadowHi;
          REG_RSVD: rdData <= '0;
          default:  rdData <= '0;
        endcase
      end
    end
  end

  assign timeNow  = timeReg;
  assign incValue = incReg;
  assign stageLow = stageReg;

endmodule

// File: rtl/systime_accum.sv
module systime_accum
  import systime_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int INC_W  = 26,
  parameter int FRAC_W = 22
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output logic [BUS_W-1:0]      regRdData,
  output logic                  regRdValid,
  output logic                  incOverflow,
  output logic [2*BUS_W-1:0]    timeNow,
  output logic [2*BUS_W-1:0]    nsNow
);

  ctl_strobe_t       ctlStrobes;
  logic [INC_W-1:0]  incValue;
  logic [BUS_W-1:0]  stageLow;

  systime_ctrl #(
    .BUS_W(BUS_W),
    .INC_W(INC_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strobes    (ctlStrobes),
    .incOverflow(incOverflow)
  );

  systime_dp #(
    .BUS_W(BUS_W),
    .INC_W(INC_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (ctlStrobes),
    .wrData  (regWrData),
    .timeNow (timeNow),
    .incValue(incValue),
    .stageLow(stageLow),
    .rdData  (regRdData),
    .rdValid (regRdValid)
  );

  assign nsNow = timeNow >> FRAC_W;

endmodule

// File: rtl/systime_accum_chk.sv
module systime_accum_chk #(
  parameter int BUS_W = 32,
  parameter int INC_W = 26
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [1:0]         regAddr,
  input logic [BUS_W-1:0]   regWrData,
  input logic [BUS_W-1:0]   regRdData,
  input logic               regRdValid,
  input logic               incOverflow,
  input logic [2*BUS_W-1:0] timeNow,
  input logic [INC_W-1:0]   incValue,
  input logic [BUS_W-1:0]   stageLow
);

  logic incWrite;
  logic incTooBig;

  assign incWrite  = regWrEn && (regAddr == 2'd0);
  assign incTooBig = ((regWrData >> INC_W) != '0);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 2'd2) |=> timeNow == $past(timeNow + (2*BUS_W)'(incValue)));

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=> timeNow == {$past(regWrData), $past(stageLow)});

  // R3
  inc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incWrite && !incTooBig) |=> incValue == $past(regWrData[INC_W-1:0]));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incWrite && incTooBig) |=> incOverflow && $stable(incValue));

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(incWrite && incTooBig) |=> !incOverflow);

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid);

  // R7
  low_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd1) |=> regRdData == $past(timeNow[BUS_W-1:0]));

endmodule

bind systime_accum systime_accum_chk #(
  .BUS_W(BUS_W),
  .INC_W(INC_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .regRdValid (regRdValid),
  .incOverflow(incOverflow),
  .timeNow    (timeNow),
  .incValue   (incValue),
  .stageLow   (stageLow)
);

// File: tb/systime_accum_tb_top.sv
module systime_accum_tb_top;

  localparam int BUS_W  = 32;
  localparam int INC_W  = 26;
  localparam int FRAC_W = 22;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [1:0]        regAddr = '0;
  logic [BUS_W-1:0]  regWrData = '0;
  logic [BUS_W-1:0]  regRdData;
  logic              regRdValid;
  logic              incOverflow;
  logic [63:0]       timeNow;
  logic [63:0]       nsNow;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  systime_accum #(
    .BUS_W(BUS_W),
    .INC_W(INC_W),
    .FRAC_W(FRAC_W)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .regRdValid (regRdValid),
    .incOverflow(incOverflow),
    .timeNow    (timeNow),
    .nsNow      (nsNow)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
    regWrData = '0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    regRdEn = 1'b1;
    regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
    check("R8 read valid", 64'(regRdValid), 64'd1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 time zero", timeNow, 64'd0);
    check("R1 rdValid low", 64'(regRdValid), 64'd0);
    check("R1 overflow low", 64'(incOverflow), 64'd0);
    repeat (3) @(negedge clk);
    check("R1 counter stopped", timeNow, 64'd0);
    rdReg(2'd0, d);
    check("R1 increment zero", 64'(d), 64'd0);
  endtask

  task automatic testLoad();
    wrReg(2'd1, 32'h89AB_CDEF);
    check("R5 stage leaves time", timeNow, 64'd0);
    wrReg(2'd2, 32'h0123_4567);
    check("R6 atomic load", timeNow, 64'h0123_4567_89AB_CDEF);
    check("R9 ns value", nsNow, 64'h0123_4567_89AB_CDEF >> 22);
  endtask

  task automatic testIncrement();
    logic [63:0] t0;
    t0 = timeNow;
    wrReg(2'd0, 32'h0200_0000);
    check("R3 old inc at write edge", timeNow, t0);
    @(negedge clk);
    check("R3 new inc next edge", timeNow, t0 + 64'h0200_0000);
    repeat (5) @(negedge clk);
    check("R2 steady advance", timeNow, t0 + 64'd6 * 64'h0200_0000);
    check("R9 ns tracks", nsNow, timeNow >> 22);
  endtask

  task automatic testRunningLoadWrap();
    logic [63:0] t0;
    t0 = timeNow;
    wrReg(2'd1, 32'hFFFF_FFF0);
    check("R5 counter undisturbed", timeNow, t0 + 64'h0200_0000);
    wrReg(2'd2, 32'hFFFF_FFFF);
    check("R6 commit while running", timeNow, 64'hFFFF_FFFF_FFFF_FFF0);
    @(negedge clk);
    check("R2 wrap modulo", timeNow, 64'h0000_0000_01FF_FFF0);
  endtask

  task automatic testReject();
    logic [63:0] t0;
    logic [31:0] d;
    t0 = timeNow;
    wrReg(2'd0, 32'h0400_0000);
    check("R4 overflow pulse", 64'(incOverflow), 64'd1);
    check("R4 old inc used", timeNow, t0 + 64'h0200_0000);
    @(negedge clk);
    check("R4 pulse one cycle", 64'(incOverflow), 64'd0);
    check("R4 inc unchanged", timeNow, t0 + 64'h0400_0000);
    rdReg(2'd0, d);
    check("R4 inc readback", 64'(d), 64'h0200_0000);
  endtask

  task automatic testSnapshot();
    logic [31:0] d;
    wrReg(2'd0, 32'h0000_0010);
    wrReg(2'd1, 32'hFFFF_FFF0);
    wrReg(2'd2, 32'h0000_0005);
    check("R6 snapshot preload", timeNow, 64'h0000_0005_FFFF_FFF0);
    rdReg(2'd1, d);
    check("R7 low word", 64'(d), 64'h0000_0000_FFFF_FFF0);
    repeat (3) @(negedge clk);
    check("R7 high moved on", timeNow, 64'h0000_0006_0000_0030);
    rdReg(2'd2, d);
    check("R7 coherent high", 64'(d), 64'd5);
  endtask

  task automatic testMisc();
    logic [31:0] d;
    rdReg(2'd3, d);
    check("R8 unused reads zero", 64'(d), 64'd0);
    @(negedge clk);
    check("R8 valid drops", 64'(regRdValid), 64'd0);
    rdReg(2'd0, d);
    check("R8 inc zero-extended", 64'(d), 64'h10);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testIncrement();
    testRunningLoadWrap();
    testReject();
    testSnapshot();
    testMisc();
    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish();
    end
  end

endmodule